// File: doc/BRIEF.md
# Signed Fixed-Point Multiplier with Binary-Point Tracking

This block multiplies two signed two's-complement operands of `W` bits each. It returns the full-precision `2W`-bit product. The product bits are the same however the operands are read, so the block also reports where the binary point sits in the product. In integer mode that position is the sum of the two operand fraction-bit counts. In fractional mode both operands are taken as 1.(W-1) values. The duplicated sign bit of the 2.(2W-2) result is then removed by a one-bit left shift, which gives a 1.(2W-1) product. The single input pair that cannot be represented after that shift is most-negative times most-negative. For that pair the product is clamped to the largest positive value and an overflow flag is raised.

A narrowing stage sits after the full product. It drops a run-time-chosen number of low bits. It either truncates toward minus infinity or rounds half up. It then saturates to the `OUT_W`-bit output, including the case where a rounding carry pushes the value past the top of the range. All results appear exactly two clock cycles after the operands, and a valid bit travels with them.

Top module: `qmul_top`

## Requirements
- R1: In integer mode (`frac_mode`=0), `prod` equals the exact signed product a×b held in 2W bits. For example, 0xFB × 0x06 gives 0xFFE2.
- R2: `prod_frac` equals `a_frac`+`b_frac` in integer mode and equals 2W-1 in fractional mode.
- R3: In fractional mode, `prod` equals the exact product shifted left by one bit. Its least significant bit is therefore 0 whenever `ovf` is 0.
- R4: In fractional mode, when both operands are the most negative value, `prod` becomes the largest positive 2W-bit value and `ovf` is 1. In every other case `ovf` is 0, and that includes all of integer mode.
- R5: With `round_en`=0, `y` is `prod` arithmetically shifted right by `drop` bits, which is a floor division by 2^drop, before saturation.
- R6: With `round_en`=1 and `drop`>0, the bit at position `drop`-1 of `prod` is added to the shifted value (round half up). With `drop`=0, `prod` is passed through unchanged.
- R7: When the shifted and rounded value lies outside the signed `OUT_W`-bit range, `y` is clamped to the nearer limit (127 or -128 at the defaults) and `sat` is 1. Otherwise `sat` is 0.
- R8: `out_valid` in a cycle equals `in_valid` from two cycles earlier, and every output belongs to that same input.
- R9: While `rst_n` is low at a clock edge, `out_valid` is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands valid this cycle |
| a | input | W | Multiplicand, signed |
| b | input | W | Multiplier, signed |
| a_frac | input | $clog2(W+1) | Fraction-bit count of `a` (integer mode) |
| b_frac | input | $clog2(W+1) | Fraction-bit count of `b` (integer mode) |
| frac_mode | input | 1 | 1 = fractional 1.(W-1) operands, 0 = integer interpretation |
| round_en | input | 1 | 1 = round half up, 0 = truncate |
| drop | input | $clog2(2W) | Low product bits discarded by narrowing |
| out_valid | output | 1 | Results valid |
| prod | output | 2W | Full-precision product |
| prod_frac | output | $clog2(2W+1) | Fraction-bit count of `prod` |
| y | output | OUT_W | Narrowed, rounded, saturated result |
| ovf | output | 1 | Fractional most-negative squared was clamped |
| sat | output | 1 | Narrowing saturated |

## Verification
Two of the block's functions can act on the same input. The fractional clamp of most-negative squared and the saturation in the narrowing stage both fire in one cycle when the clamped product is narrowed with a small `drop`, or with `drop`=8 and rounding on, where the round-up carries past 127. Directed vectors apply exactly these pairs, and the bench expects `ovf` and `sat` both high together with `y`=127. The same pairs are also sent with truncation, which must leave `sat` low where the floor stays in range. A behavioural model on integers predicts every field, and the bench compares each field on every valid output cycle.

// File: rtl/qmul_pkg.sv
// Package: shared encodings for the fixed-point multiplier.
// Assumes: nothing beyond IEEE 1800-2017.
package qmul_pkg;
    typedef enum logic {MODE_INT = 1'b0, MODE_FRAC = 1'b1} mul_mode_e;
    typedef enum logic {NARROW_TRUNC = 1'b0, NARROW_HALF_UP = 1'b1} narrow_e;
endpackage

// File: rtl/qmul_pp_mult.sv
// Module: signed array multiplier built from sign-extended partial products.
// Assumes: two's-complement operands; the weight of the multiplier's top bit is
// negative, so that row is subtracted. Purely combinational.
module qmul_pp_mult #(
    parameter int W = 8
) (
    input  logic signed [W-1:0]   a,
    input  logic signed [W-1:0]   b,
    output logic signed [2*W-1:0] p
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] rows [W];

    assign a_ext = PW'(a);

    // One row per multiplier bit; the sign row carries negative weight.
    for (genvar i = 0; i < W; i++) begin : g_row
        if (i == W - 1) begin : g_sign
            assign rows[i] = b[i] ? -(a_ext <<< i) : '0;
        end else begin : g_mag
            assign rows[i] = b[i] ? (a_ext <<< i) : '0;
        end
    end

    // Sum of all rows, modulo 2^(2W).
    always_comb begin
        p = '0;
        for (int i = 0; i < W; i++) p = p + rows[i];
    end
endmodule

// File: rtl/qmul_frac_align.sv
// Module: fractional alignment. Removes the duplicated sign bit with a left
// shift and clamps the single unrepresentable case.
// Assumes: the input is an exact W x W signed product; only (-2^(W-1))^2
// equals 2^(2W-2), so that value alone identifies the overflow.
module qmul_frac_align #(
    parameter int W = 8
) (
    input  qmul_pkg::mul_mode_e     mode,
    input  logic signed [2*W-1:0]   raw,
    output logic signed [2*W-1:0]   aligned,
    output logic                    ovf
);
    import qmul_pkg::*;
    localparam int PW = 2 * W;
    localparam logic [PW-1:0] MIN_SQ = {2'b01, {(PW-2){1'b0}}};
    localparam logic [PW-1:0] POS_MAX = {1'b0, {(PW-1){1'b1}}};

    // Choose pass-through, left shift, or clamp.
    always_comb begin
        ovf     = 1'b0;
        aligned = raw;
        if (mode == MODE_FRAC) begin
            if (raw == MIN_SQ) begin
                ovf     = 1'b1;
                aligned = POS_MAX;
            end else begin
                aligned = raw <<< 1;
            end
        end
    end
endmodule

// File: rtl/qmul_narrow.sv
// Module: output narrowing. Arithmetic right shift by a run-time amount,
// optional round-half-up, then signed saturation to OW bits.
// Assumes: OW <= IW and OW < 32; shift amount below IW.
module qmul_narrow #(
    parameter int IW = 16,
    parameter int OW = 8,
    parameter int DW = 4
) (
    input  logic signed [IW-1:0] x,
    input  logic [DW-1:0]        shamt,
    input  qmul_pkg::narrow_e    rmode,
    output logic signed [OW-1:0] y,
    output logic                 sat
);
    import qmul_pkg::*;
    localparam int EW = IW + 1;
    localparam logic signed [EW-1:0] HI = EW'((64'sd1 <<< (OW - 1)) - 64'sd1);
    localparam logic signed [EW-1:0] LO = -HI - EW'(1);

    logic signed [EW-1:0] ext;
    logic signed [EW-1:0] shifted;
    logic signed [EW-1:0] half;
    logic signed [EW-1:0] rounded;

    assign ext = EW'(x);

    // Shift and add the rounding bit when requested.
    always_comb begin
        shifted = ext >>> shamt;
        half    = '0;
        if (rmode == NARROW_HALF_UP && shamt != '0)
            half = EW'((ext >>> (shamt - DW'(1))) & EW'(1));
        rounded = shifted + half;
    end

    // Clamp to the signed output range.
    always_comb begin
        sat = 1'b0;
        y   = OW'(rounded);
        if (rounded > HI) begin
            sat = 1'b1;
            y   = OW'(HI);
        end else if (rounded < LO) begin
            sat = 1'b1;
            y   = OW'(LO);
        end
    end
endmodule

// File: rtl/qmul_top.sv
// Module: two-stage signed fixed-point multiplier with binary-point tracking.
// Stage 1 registers the raw product and controls; stage 2 registers the
// aligned product, its fraction count and the narrowed result.
// Assumes: a_frac and b_frac do not exceed W; synchronous active-low reset
// clears the valid pipe only.
module qmul_top #(
    parameter int W     = 8,
    parameter int OUT_W = 8,
    localparam int PW   = 2 * W,
    localparam int FW   = $clog2(W + 1),
    localparam int PFW  = $clog2(2 * W + 1),
    localparam int DW   = $clog2(2 * W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic signed [W-1:0]   a,
    input  logic signed [W-1:0]   b,
    input  logic [FW-1:0]         a_frac,
    input  logic [FW-1:0]         b_frac,
    input  logic                  frac_mode,
    input  logic                  round_en,
    input  logic [DW-1:0]         drop,
    output logic                  out_valid,
    output logic signed [PW-1:0]  prod,
    output logic [PFW-1:0]        prod_frac,
    output logic signed [OUT_W-1:0] y,
    output logic                  ovf,
    output logic                  sat
);
    import qmul_pkg::*;
    localparam logic [PW-1:0] POS_MAX = {1'b0, {(PW-1){1'b1}}};

    logic signed [PW-1:0]    raw_c;
    logic                    s1_valid;
    logic signed [PW-1:0]    s1_raw;
    mul_mode_e               s1_mode;
    narrow_e                 s1_rnd;
    logic [DW-1:0]           s1_drop;
    logic [PFW-1:0]          s1_pfrac;
    logic signed [PW-1:0]    al_c;
    logic                    ovf_c;
    logic signed [OUT_W-1:0] y_c;
    logic                    sat_c;
    mul_mode_e               s2_mode;

    qmul_pp_mult #(.W(W)) u_mult (.a(a), .b(b), .p(raw_c));

    // Stage 1: capture raw product, controls and the product's point position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= in_valid;
        end
        s1_raw   <= raw_c;
        s1_mode  <= frac_mode ? MODE_FRAC : MODE_INT;
        s1_rnd   <= round_en ? NARROW_HALF_UP : NARROW_TRUNC;
        s1_drop  <= drop;
        s1_pfrac <= frac_mode ? PFW'(PW - 1) : PFW'(a_frac) + PFW'(b_frac);
    end

    qmul_frac_align #(.W(W)) u_align (
        .mode(s1_mode), .raw(s1_raw), .aligned(al_c), .ovf(ovf_c)
    );

    qmul_narrow #(.IW(PW), .OW(OUT_W), .DW(DW)) u_narrow (
        .x(al_c), .shamt(s1_drop), .rmode(s1_rnd), .y(y_c), .sat(sat_c)
    );

    // Stage 2: register all results together with the valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= s1_valid;
        end
        prod      <= al_c;
        prod_frac <= s1_pfrac;
        y         <= y_c;
        ovf       <= ovf_c;
        sat       <= sat_c;
        s2_mode   <= s1_mode;
    end

    // R8: output valid follows input valid two edges later.
    assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R4: a clamp leaves the largest positive product.
    assert_ovf_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ovf) |-> (prod == POS_MAX));

    // R4: the clamp only occurs for a fractional request.
    assert_ovf_frac_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ovf) |-> $past(frac_mode, 2));

    // R3: an unclamped fractional product has a zero LSB.
    assert_frac_lsb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && s2_mode == MODE_FRAC && !ovf) |-> (prod[0] == 1'b0));

    // R7: a saturated result sits on one of the two rails.
    assert_sat_rail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && sat) |-> (y == {1'b0, {(OUT_W-1){1'b1}}} || y == {1'b1, {(OUT_W-1){1'b0}}}));
endmodule

// File: tb/test_qmul_top.sv
module test_qmul_top;
    localparam int W = 8;
    localparam int OUT_W = 8;
    localparam int PW = 2 * W;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid;
    logic signed [W-1:0] a, b;
    logic [3:0] a_frac, b_frac;
    logic frac_mode, round_en;
    logic [3:0] drop;
    logic out_valid;
    logic signed [PW-1:0] prod;
    logic [4:0] prod_frac;
    logic signed [OUT_W-1:0] y;
    logic ovf, sat;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        bit     v;
        longint prod;
        int     pfrac;
        longint y;
        bit     ovf;
        bit     sat;
        bit     frac;
        bit     rnd;
    } exp_t;

    exp_t pipe[$];

    qmul_top #(.W(W), .OUT_W(OUT_W)) i_qmul_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
        .a_frac(a_frac), .b_frac(b_frac), .frac_mode(frac_mode),
        .round_en(round_en), .drop(drop), .out_valid(out_valid),
        .prod(prod), .prod_frac(prod_frac), .y(y), .ovf(ovf), .sat(sat)
    );

    always #10 clk = ~clk;

    function automatic exp_t model(bit v, longint av, longint bv, int af, int bf,
                                   bit fm, bit rn, int d);
        exp_t e;
        longint raw, f, q, hi, lo;
        raw = av * bv;
        e.v = v; e.frac = fm; e.rnd = rn; e.ovf = 0; e.sat = 0;
        if (fm) begin
            if (av == -128 && bv == -128) begin
                f = 32767; e.ovf = 1;
            end else f = raw * 2;
            e.pfrac = PW - 1;
        end else begin
            f = raw;
            e.pfrac = af + bf;
        end
        e.prod = f;
        q = f >>> d;
        if (rn && d > 0) q = q + ((f >>> (d - 1)) & 1);
        hi = 127; lo = -128;
        if (q > hi) begin q = hi; e.sat = 1; end
        else if (q < lo) begin q = lo; e.sat = 1; end
        e.y = q;
        return e;
    endfunction

    task automatic check(bit ok, string req, longint act, longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic compare_out();
        exp_t e;
        if (pipe.size() < 2) return;
        e = pipe.pop_front();
        check(out_valid == e.v, "R8 valid", out_valid, e.v);
        if (e.v) begin
            check(longint'(prod) == e.prod, e.frac ? "R3 prod" : "R1 prod", prod, e.prod);
            check(int'(prod_frac) == e.pfrac, "R2 prod_frac", prod_frac, e.pfrac);
            check(ovf == e.ovf, "R4 ovf", ovf, e.ovf);
            check(longint'(y) == e.y, e.rnd ? "R6 y" : "R5 y", y, e.y);
            check(sat == e.sat, "R7 sat", sat, e.sat);
        end
    endtask

    task automatic step(bit v, int av, int bv, int af, int bf, bit fm, bit rn, int d);
        @(negedge clk);
        compare_out();
        in_valid = v; a = W'(av); b = W'(bv); a_frac = 4'(af); b_frac = 4'(bf);
        frac_mode = fm; round_en = rn; drop = 4'(d);
        pipe.push_back(model(v, av, bv, af, bf, fm, rn, d));
    endtask

    initial begin
        rst_n = 0; in_valid = 1; a = 0; b = 0; a_frac = 0; b_frac = 0;
        frac_mode = 0; round_en = 0; drop = 0;
        repeat (3) @(negedge clk);
        // R9: valid cleared during reset even with in_valid high
        check(out_valid == 1'b0, "R9 reset", out_valid, 0);
        in_valid = 0;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 reset", out_valid, 0);
        rst_n = 1;
        // R1/R2: 0xFB x 0x06 = 0xFFE2 in any format
        step(1, -5, 6, 0, 0, 0, 0, 0);
        step(1, -5, 6, 3, 2, 0, 0, 4);
        step(1, -5, 6, 7, 7, 0, 1, 4);
        // R3/R4: fractional, including most-negative squared
        step(1, -5, 6, 0, 0, 1, 0, 8);
        step(1, -128, -128, 0, 0, 1, 0, 8);
        step(1, -128, -128, 0, 0, 0, 0, 0);
        // R4 with R7 together: clamp then narrowing saturation / rounding carry
        step(1, -128, -128, 0, 0, 1, 0, 0);
        step(1, -128, -128, 0, 0, 1, 1, 8);
        step(1, -128, 127, 0, 0, 1, 1, 8);
        // R6/R7: rounding carries 127.5 past the top rail
        step(1, 15, 17, 0, 0, 0, 1, 1);
        step(1, 15, 17, 0, 0, 0, 0, 1);
        // R5: truncation floors negative values, R6 ties go up
        step(1, -3, 1, 0, 0, 0, 0, 1);
        step(1, -3, 1, 0, 0, 0, 1, 1);
        step(0, 1, 1, 0, 0, 0, 0, 0);
        step(1, 127, 127, 0, 0, 0, 1, 15);
        step(1, -128, 127, 0, 0, 0, 0, 15);
        // R8: random traffic with gaps
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) != 0, int'($urandom % 256) - 128, int'($urandom % 256) - 128,
                 int'($urandom % 9), int'($urandom % 9), 1'($urandom), 1'($urandom),
                 int'($urandom % 16));
        end
        step(0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule